// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two independent direction predictors and a trained selector. The per-branch component keeps a short outcome history for each branch slot and uses that history to pick a 2-bit counter. The shared-history component joins a global outcome register with low PC bits to pick a counter from its own table. A third table of 2-bit counters, indexed by PC, picks which of the two answers is passed on.

A fetch stage presents a PC on the lookup port and receives the registered prediction one cycle later, together with both component predictions. It keeps those until the branch resolves. The back end then returns the PC, the real outcome and the two component predictions on the update port. The block trains both component counters, trains the selector when the components disagreed, and shifts the outcome into both histories. History is not repaired after a wrong-path update. Every table size is a parameter; the defaults are scaled down.

Top module: `tourn_bp`

## Requirements
- R1: After reset every counter is 01 (weakly not-taken) and every history is zero, so the first lookups return taken=0 for the final, per-branch and shared-history predictions.
- R2: `pred_valid` is high in exactly the cycles that follow a cycle with `lkp_valid` high, and the predictions then belong to that lookup.
- R3: The shared-history prediction is the MSB of the counter at index {ghr, pc[GPC_W-1:0]}, with the history in the upper bits.
- R4: The per-branch prediction is the MSB of the counter indexed by the history entry that pc[LPC_W-1:0] selects.
- R5: The final prediction is the shared-history prediction when the selector counter at pc[CH_W-1:0] has MSB 1, and the per-branch prediction otherwise.
- R6: Counters saturate: an increment at 11 stays at 11 and a decrement at 00 stays at 00. An update moves both component counters, addressed with the pre-update histories, one step toward the outcome.
- R7: An update shifts the outcome into bit 0 of the global history and of the addressed per-branch history. The oldest bit is dropped.
- R8: The selector moves toward 11 when only the shared-history component was right, and toward 00 when only the per-branch component was right. It is unchanged when the two components agree.
- R9: With `upd_valid` low, the update fields have no effect on any table or history.
- R10: A lookup in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_pc | input | PC_W | Branch PC to predict |
| pred_valid | output | 1 | Prediction valid (one cycle after lookup) |
| pred_taken | output | 1 | Final prediction |
| pred_local | output | 1 | Per-branch component prediction |
| pred_global | output | 1 | Shared-history component prediction |
| upd_valid | input | 1 | Update request |
| upd_pc | input | PC_W | Resolved branch PC |
| upd_taken | input | 1 | Actual outcome |
| upd_local | input | 1 | Per-branch prediction made at lookup |
| upd_global | input | 1 | Shared-history prediction made at lookup |

## Verification
A corrupted counter or history entry shows up at the ports as a wrong component bit on the next lookup that reaches the bad entry. Because the component bits are output separately, the fault can be traced to the per-branch or the shared-history path. A wrong selector counter changes only `pred_taken`, and only while the two components disagree. A bad global history bit hits every lookup in the very next cycle and stays visible for GH_W updates, until the bit is shifted out.

// File: rtl/tourn_bp_pkg.sv
package tourn_bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  // one saturating step toward the given direction
  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_taken(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tourn_ctr_table.sv
module tourn_ctr_table #(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_idx,
  output tourn_bp_pkg::ctr_t  rd_ctr,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_up
);
  import tourn_bp_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];
  ctr_t wr_old;
  ctr_t wr_new;

  assign rd_ctr = tbl[rd_idx];
  assign wr_old = tbl[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_RESET;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_new;
    end
  end

  // R6
  ctr_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl[$past(wr_idx)] == $past(wr_new));
endmodule

// File: rtl/tourn_lhist_table.sv
module tourn_lhist_table #(
  parameter int ENT_W  = 4,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ENT_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist_old
);
  localparam int DEPTH = 1 << ENT_W;

  logic [HIST_W-1:0] tbl [DEPTH];

  assign rd_hist     = tbl[rd_idx];
  assign wr_hist_old = tbl[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= {wr_hist_old[HIST_W-2:0], wr_bit};
    end
  end

  // R7
  lhist_newest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl[$past(wr_idx)][0] == $past(wr_bit));
endmodule

// File: rtl/tourn_bp.sv
module tourn_bp #(
  parameter int PC_W  = 16,
  parameter int GH_W  = 4,
  parameter int GPC_W = 4,
  parameter int LPC_W = 4,
  parameter int LH_W  = 8,
  parameter int CH_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lkp_valid,
  input  logic [PC_W-1:0] lkp_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local,
  input  logic            upd_global
);
  import tourn_bp_pkg::*;
  localparam int GIDX_W = GH_W + GPC_W;

  logic [GH_W-1:0]   ghr;
  logic [LH_W-1:0]   lk_lhist, up_lhist;
  ctr_t              lk_gctr, lk_lctr, lk_chctr;
  logic [GIDX_W-1:0] lk_gidx, up_gidx;
  logic              ch_wr_en, ch_wr_up;
  logic              lk_sel_global;

  assign lk_gidx  = {ghr, lkp_pc[GPC_W-1:0]};
  assign up_gidx  = {ghr, upd_pc[GPC_W-1:0]};
  assign ch_wr_en = upd_valid && (upd_local != upd_global);
  assign ch_wr_up = (upd_global == upd_taken);
  assign lk_sel_global = ctr_taken(lk_chctr);

  tourn_ctr_table #(.IDX_W(GIDX_W)) u_gtab (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_gidx), .rd_ctr(lk_gctr),
    .wr_en(upd_valid), .wr_idx(up_gidx), .wr_up(upd_taken));

  tourn_lhist_table #(.ENT_W(LPC_W), .HIST_W(LH_W)) u_lht (
    .clk(clk), .rst_n(rst_n), .rd_idx(lkp_pc[LPC_W-1:0]), .rd_hist(lk_lhist),
    .wr_en(upd_valid), .wr_idx(upd_pc[LPC_W-1:0]), .wr_bit(upd_taken),
    .wr_hist_old(up_lhist));

  tourn_ctr_table #(.IDX_W(LH_W)) u_ltab (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_lhist), .rd_ctr(lk_lctr),
    .wr_en(upd_valid), .wr_idx(up_lhist), .wr_up(upd_taken));

  tourn_ctr_table #(.IDX_W(CH_W)) u_chooser (
    .clk(clk), .rst_n(rst_n), .rd_idx(lkp_pc[CH_W-1:0]), .rd_ctr(lk_chctr),
    .wr_en(ch_wr_en), .wr_idx(upd_pc[CH_W-1:0]), .wr_up(ch_wr_up));

  always_ff @(posedge clk) begin
    if (!rst_n) ghr <= '0;
    else if (upd_valid) ghr <= {ghr[GH_W-2:0], upd_taken};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
      pred_local  <= 1'b0;
      pred_global <= 1'b0;
    end else begin
      pred_valid <= lkp_valid;
      if (lkp_valid) begin
        pred_local  <= ctr_taken(lk_lctr);
        pred_global <= ctr_taken(lk_gctr);
        pred_taken  <= lk_sel_global ? ctr_taken(lk_gctr) : ctr_taken(lk_lctr);
      end
    end
  end

  // R2
  pred_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> pred_valid);
  // R2
  pred_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !pred_valid);
  // R5
  pred_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && (pred_local == pred_global)) |-> (pred_taken == pred_local));
  // R7
  ghr_newest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghr[0] == $past(upd_taken));
  // R9
  ghr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghr));
endmodule

// File: tb/tb_tourn_bp.sv
`timescale 1ns/1ps
module tb_tourn_bp;
  localparam int PC_W = 16, GH_W = 4, GPC_W = 4, LPC_W = 4, LH_W = 8, CH_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lkp_valid = 1'b0;
  logic [PC_W-1:0] lkp_pc = '0;
  logic pred_valid, pred_taken, pred_local, pred_global;
  logic upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic upd_taken = 1'b0, upd_local = 1'b0, upd_global = 1'b0;

  always #2.5 clk = ~clk;

  tourn_bp #(.PC_W(PC_W), .GH_W(GH_W), .GPC_W(GPC_W), .LPC_W(LPC_W),
             .LH_W(LH_W), .CH_W(CH_W)) dut (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_local(pred_local),
    .pred_global(pred_global), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_local(upd_local), .upd_global(upd_global));

  int checks = 0, errors = 0;
  int m_g [1 << (GH_W + GPC_W)];
  int m_l [1 << LH_W];
  int m_c [1 << CH_W];
  int m_h [1 << LPC_W];
  int m_ghr;

  bit pend_v;
  int exp_t, exp_l, exp_g;
  string pend_tag;

  function automatic int sat(int c, bit up);
    if (up) return (c >= 3) ? 3 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  function automatic int gidx(int pc);
    return (m_ghr << GPC_W) | (pc % (1 << GPC_W));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_g[i]) m_g[i] = 1;
    foreach (m_l[i]) m_l[i] = 1;
    foreach (m_c[i]) m_c[i] = 1;
    foreach (m_h[i]) m_h[i] = 0;
    m_ghr = 0;
  endtask

  // one cycle: check previous lookup, predict from model, update model, drive
  task automatic step(string tag, bit lv, int lpc, bit uv, int upc, bit ut, bit ul, bit ug);
    int li, gi, hi;
    @(negedge clk);
    chk(pend_tag, "R2 pred_valid", pred_valid, pend_v);
    if (pend_v) begin
      chk(pend_tag, "R4 pred_local", pred_local, exp_l);
      chk(pend_tag, "R3 pred_global", pred_global, exp_g);
      chk(pend_tag, "R5 pred_taken", pred_taken, exp_t);
    end
    // R10: expectation uses state before this cycle's update
    pend_v = lv;
    pend_tag = tag;
    if (lv) begin
      exp_l = (m_l[m_h[lpc % (1 << LPC_W)]] >= 2);
      exp_g = (m_g[gidx(lpc)] >= 2);
      exp_t = (m_c[lpc % (1 << CH_W)] >= 2) ? exp_g : exp_l;
    end
    if (uv) begin
      hi = upc % (1 << LPC_W);
      li = m_h[hi];
      gi = gidx(upc);
      m_g[gi] = sat(m_g[gi], ut);
      m_l[li] = sat(m_l[li], ut);
      if (ul != ug) m_c[upc % (1 << CH_W)] = sat(m_c[upc % (1 << CH_W)], ug == ut);
      m_ghr = ((m_ghr << 1) | ut) % (1 << GH_W);
      m_h[hi] = ((li << 1) | ut) % (1 << LH_W);
    end
    lkp_valid = lv; lkp_pc = lpc[PC_W-1:0];
    upd_valid = uv; upd_pc = upc[PC_W-1:0];
    upd_taken = ut; upd_local = ul; upd_global = ug;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0017;
    void'($urandom(seed));
    model_reset();
    pend_v = 0; pend_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: fresh lookups all predict not-taken
    for (int i = 0; i < 8; i++) step("R1", 1, i * 37, 0, 0, 0, 0, 0);
    // R6: drive one branch to saturation and back
    for (int i = 0; i < 12; i++) step("R6", 1, 5, 1, 5, 1, 1, 1);
    for (int i = 0; i < 12; i++) step("R6", 1, 5, 1, 5, 0, 0, 0);
    // R7: alternating outcome patterns move both histories
    for (int i = 0; i < 20; i++) step("R7", 1, 9, 1, 9, i[0], 0, 0);
    // R8: components disagree; shared-history one right, then per-branch one right
    for (int i = 0; i < 6; i++) step("R8", 1, 3, 1, 3, 1, 0, 1);
    for (int i = 0; i < 6; i++) step("R8", 1, 3, 1, 3, 1, 1, 0);
    for (int i = 0; i < 6; i++) step("R8", 1, 3, 1, 3, 0, 0, 0);
    // R9: junk on update fields with upd_valid low
    for (int i = 0; i < 30; i++)
      step("R9", 1, $urandom % 64, 0, $urandom % 64, $urandom % 2, $urandom % 2, $urandom % 2);
    // R10: lookup and update of the same PC in one cycle
    for (int i = 0; i < 30; i++) step("R10", 1, 7, 1, 7, 1, 0, 1);
    // random mix over a small PC set
    for (int i = 0; i < 3000; i++) begin
      int p, q;
      p = $urandom % 24;
      q = $urandom % 24;
      step("R5", $urandom % 4 != 0, p, $urandom % 3 != 0, q,
           $urandom % 2, $urandom % 2, $urandom % 2);
    end
    step("R2", 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule